// File: doc/BRIEF.md
# Linked Ping-Pong DMA Writer

This block moves 32-bit samples from a fixed peripheral receive register into memory without processor help. Each stream channel waits for a receive event and captures the word the peripheral presents. It then issues one memory write to the current destination and steps the destination by one word. Two channels are instantiated, one for the sign stream and one for the magnitude stream, and each has its own pair of buffers.

Each channel holds a small table of parameter sets. Every set gives a destination buffer and a link to the next set. The boot set targets the ping buffer and links to the pong set. The pong set links to a second ping set, and that set links back to the pong set. When the element count of the active set runs out, the channel loads the linked set in the same cycle that it issues the final write. The first pass therefore fills ping, and the channel then alternates between pong and ping with no gap in event acceptance.

Completing a buffer raises a per-channel pending flag on a single shared interrupt line. A status bit tells software which buffer was just filled. Software clears the pending flag with an acknowledge pulse. An event that arrives while a write is still waiting for its grant is dropped and recorded in a missed flag.

Top module: `dmapp_linked_writer`

## Requirements
- R1: After reset, no write is requested, irq is 0, every done_pend and missed bit is 0, and the first write of each channel goes to its ping base.
- R2: An event seen while no write of that channel is outstanding raises wr_req in the next cycle. wr_data carries the rx_data value sampled with the event. The request, address and data hold unchanged until a cycle in which wr_gnt is high, and wr_req is low in the cycle after that.
- R3: Destinations are byte addresses. Successive elements of a buffer are written to base, base+4, base+8 and so on, up to BUF_WORDS words.
- R4: Buffers are filled in the order ping, pong, ping, pong and so on indefinitely. The bases are ping = PING_BASES slice and pong = PONG_BASES slice.
- R5: The parameter reload costs no cycles. An event in the first cycle after the final write of a buffer is granted is accepted, and it writes the first word of the next buffer.
- R6: The cycle after the final write of a buffer is granted, done_pend of that channel is 1, done_buf shows the buffer just filled (0 = ping, 1 = pong), and irq is 1.
- R7: An irq_ack pulse clears done_pend and missed of its channel, and irq falls when no channel is pending. A completion in the same cycle as an acknowledge takes priority, so done_pend stays 1.
- R8: An event that arrives while a write is outstanding, including in the cycle of its grant, causes no write and does not advance the destination. It sets missed.
- R9: The channels are independent. Events, grants and acknowledges of one channel do not change the writes or flags of the other.
- R10: A further completion while done_pend is still set keeps done_pend at 1 and updates done_buf to the newest buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_evt | input | NCH | Receive event per channel |
| rx_data | input | NCH*32 | Peripheral receive word per channel |
| wr_req | output | NCH | Write request per channel |
| wr_gnt | input | NCH | Memory accepts the pending write |
| wr_addr | output | NCH*AW | Write byte address per channel |
| wr_data | output | NCH*32 | Write data per channel |
| irq_ack | input | NCH | Software acknowledge per channel |
| irq | output | 1 | Shared completion interrupt |
| done_pend | output | NCH | Completion pending per channel |
| done_buf | output | NCH | Last filled buffer per channel, 0 ping, 1 pong |
| missed | output | NCH | Event dropped while busy, per channel |

## Verification
A wrong active-set index or a wrong element count shows first on wr_addr. It appears either as a jump to the wrong base or as a buffer boundary at the wrong element, on the first write after the error, and so within one buffer of BUF_WORDS events. A bad reload shows in done_buf and done_pend at the next completion. A busy flag that is not cleared shows as a lost write together with a spurious missed bit on the following event. The bench follows every address in the expected sequence across several full ping-pong cycles, so each of these faults is seen within a few dozen cycles.

// File: rtl/dmapp_pkg.sv
package dmapp_pkg;

    localparam int WORD_BITS  = 32;
    localparam int WORD_BYTES = WORD_BITS / 8;
    localparam int NUM_SETS   = 4;

    typedef enum logic {
        BUF_PING = 1'b0,
        BUF_PONG = 1'b1
    } buf_sel_e;

    typedef logic [1:0] set_idx_t;

    typedef struct packed {
        buf_sel_e target;
        set_idx_t link;
    } set_desc_t;

    localparam set_idx_t SET_BOOT = 2'd1;

    // Link chain: boot(ping) -> pong -> ping -> pong ...
    function automatic set_desc_t set_lookup(input set_idx_t idx);
        set_desc_t d;
        case (idx)
            2'd1:    d = '{target: BUF_PING, link: 2'd2};
            2'd2:    d = '{target: BUF_PONG, link: 2'd3};
            2'd3:    d = '{target: BUF_PING, link: 2'd2};
            default: d = '{target: BUF_PING, link: 2'd2};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dmapp_link_table.sv
module dmapp_link_table
    import dmapp_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [AW-1:0] PING_BASE = '0,
    parameter logic [AW-1:0] PONG_BASE = '0
) (
    input  set_idx_t      idx,
    output logic [AW-1:0] base,
    output buf_sel_e      target,
    output set_idx_t      link
);

    logic [AW-1:0] base_tab   [NUM_SETS];
    set_desc_t     desc_tab   [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        assign desc_tab[s] = set_lookup(set_idx_t'(s));
        assign base_tab[s] = (desc_tab[s].target == BUF_PONG) ? PONG_BASE : PING_BASE;
    end

    always_comb begin
        base   = base_tab[idx];
        target = desc_tab[idx].target;
        link   = desc_tab[idx].link;
    end

endmodule

// File: rtl/dmapp_chan.sv
module dmapp_chan
    import dmapp_pkg::*;
#(
    parameter int            AW        = 16,
    parameter int            BUF_WORDS = 8,
    parameter logic [AW-1:0] PING_BASE = '0,
    parameter logic [AW-1:0] PONG_BASE = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 evt,
    input  logic [WORD_BITS-1:0] rd_word,
    output logic                 wr_req,
    input  logic                 wr_gnt,
    output logic [AW-1:0]        wr_addr,
    output logic [WORD_BITS-1:0] wr_data,
    input  logic                 ack,
    output logic                 pend,
    output logic                 last_buf,
    output logic                 missed
);

    localparam int            CW     = $clog2(BUF_WORDS + 1);
    localparam logic [AW-1:0] STRIDE = AW'(WORD_BYTES);
    localparam logic [AW-1:0] SPAN   = AW'(BUF_WORDS * WORD_BYTES);
    localparam logic [CW-1:0] FULL   = CW'(BUF_WORDS);

    // active parameters
    logic [AW-1:0] act_addr;
    logic [CW-1:0] act_left;
    set_idx_t      act_link;
    buf_sel_e      act_buf;

    // outstanding write
    logic                 busy;
    logic [AW-1:0]        wq_addr;
    logic [WORD_BITS-1:0] wq_data;
    logic                 wq_last;
    buf_sel_e             wq_buf;

    logic [AW-1:0] nxt_base, boot_base;
    buf_sel_e      nxt_tgt,  boot_tgt;
    set_idx_t      nxt_link, boot_link;

    dmapp_link_table #(.AW(AW), .PING_BASE(PING_BASE), .PONG_BASE(PONG_BASE)) u_next_tbl (
        .idx(act_link), .base(nxt_base), .target(nxt_tgt), .link(nxt_link)
    );

    dmapp_link_table #(.AW(AW), .PING_BASE(PING_BASE), .PONG_BASE(PONG_BASE)) u_boot_tbl (
        .idx(SET_BOOT), .base(boot_base), .target(boot_tgt), .link(boot_link)
    );

    logic accept, retire, final_elem;
    assign accept     = evt && !busy;
    assign retire     = busy && wr_gnt;
    assign final_elem = (act_left == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_addr <= boot_base;
            act_left <= FULL;
            act_link <= boot_link;
            act_buf  <= boot_tgt;
            busy     <= 1'b0;
            wq_addr  <= '0;
            wq_data  <= '0;
            wq_last  <= 1'b0;
            wq_buf   <= BUF_PING;
            pend     <= 1'b0;
            last_buf <= 1'b0;
            missed   <= 1'b0;
        end else begin
            if (retire)
                busy <= 1'b0;

            if (accept) begin
                busy    <= 1'b1;
                wq_addr <= act_addr;
                wq_data <= rd_word;
                wq_last <= final_elem;
                wq_buf  <= act_buf;
                if (final_elem) begin
                    act_addr <= nxt_base;
                    act_left <= FULL;
                    act_link <= nxt_link;
                    act_buf  <= nxt_tgt;
                end else begin
                    act_addr <= act_addr + STRIDE;
                    act_left <= act_left - CW'(1);
                end
            end

            if (ack) begin
                pend   <= 1'b0;
                missed <= 1'b0;
            end
            if (evt && busy)
                missed <= 1'b1;
            if (retire && wq_last) begin
                pend     <= 1'b1;
                last_buf <= (wq_buf == BUF_PONG);
            end
        end
    end

    assign wr_req  = busy;
    assign wr_addr = wq_addr;
    assign wr_data = wq_data;

    // R2
    hold_until_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_gnt) |=> (busy && $stable(wq_addr) && $stable(wq_data)));

    // R3
    addr_in_buf_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((wq_addr >= PING_BASE && wq_addr < PING_BASE + SPAN) ||
                  (wq_addr >= PONG_BASE && wq_addr < PONG_BASE + SPAN)));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (act_left != '0) && (act_left <= FULL));

    // R6
    pend_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(busy && wr_gnt && wq_last));

    // R8
    missed_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(missed) |-> $past(evt && busy));

endmodule

// File: rtl/dmapp_irq_merge.sv
module dmapp_irq_merge #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pend,
    output logic           irq
);

    assign irq = |pend;

    // R7
    irq_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq);

endmodule

// File: rtl/dmapp_linked_writer.sv
module dmapp_linked_writer
    import dmapp_pkg::*;
#(
    parameter int                NCH        = 2,
    parameter int                AW         = 16,
    parameter int                BUF_WORDS  = 8,
    parameter logic [NCH*AW-1:0] PING_BASES = {16'h0200, 16'h0000},
    parameter logic [NCH*AW-1:0] PONG_BASES = {16'h0300, 16'h0100}
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCH-1:0]           rx_evt,
    input  logic [NCH*WORD_BITS-1:0] rx_data,
    output logic [NCH-1:0]           wr_req,
    input  logic [NCH-1:0]           wr_gnt,
    output logic [NCH*AW-1:0]        wr_addr,
    output logic [NCH*WORD_BITS-1:0] wr_data,
    input  logic [NCH-1:0]           irq_ack,
    output logic                     irq,
    output logic [NCH-1:0]           done_pend,
    output logic [NCH-1:0]           done_buf,
    output logic [NCH-1:0]           missed
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dmapp_chan #(
            .AW(AW),
            .BUF_WORDS(BUF_WORDS),
            .PING_BASE(PING_BASES[c*AW +: AW]),
            .PONG_BASE(PONG_BASES[c*AW +: AW])
        ) u_chan (
            .clk(clk),
            .rst(rst),
            .evt(rx_evt[c]),
            .rd_word(rx_data[c*WORD_BITS +: WORD_BITS]),
            .wr_req(wr_req[c]),
            .wr_gnt(wr_gnt[c]),
            .wr_addr(wr_addr[c*AW +: AW]),
            .wr_data(wr_data[c*WORD_BITS +: WORD_BITS]),
            .ack(irq_ack[c]),
            .pend(done_pend[c]),
            .last_buf(done_buf[c]),
            .missed(missed[c])
        );
    end

    dmapp_irq_merge #(.NCH(NCH)) u_irq (
        .clk(clk),
        .rst(rst),
        .pend(done_pend),
        .irq(irq)
    );

endmodule

// File: tb/dmapp_linked_writer_tb_top.sv
module dmapp_linked_writer_tb_top;

    localparam int NCH  = 2;
    localparam int AW   = 16;
    localparam int BUFW = 8;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NCH-1:0]      rx_evt = '0;
    logic [NCH*32-1:0]   rx_data = '0;
    logic [NCH-1:0]      wr_req;
    logic [NCH-1:0]      wr_gnt = '0;
    logic [NCH*AW-1:0]   wr_addr;
    logic [NCH*32-1:0]   wr_data;
    logic [NCH-1:0]      irq_ack = '0;
    logic                irq;
    logic [NCH-1:0]      done_pend, done_buf, missed;

    always #2 clk = ~clk;

    dmapp_linked_writer #(.NCH(NCH), .AW(AW), .BUF_WORDS(BUFW)) dut_i (
        .clk(clk), .rst(rst), .rx_evt(rx_evt), .rx_data(rx_data),
        .wr_req(wr_req), .wr_gnt(wr_gnt), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_ack(irq_ack), .irq(irq), .done_pend(done_pend),
        .done_buf(done_buf), .missed(missed)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int exp_idx [NCH];
    int exp_buf [NCH];

    function automatic int base_of(input int ch, input int b);
        return ch * 32'h200 + b * 32'h100;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // starts and ends at a negedge with all strobes low
    task automatic issue(input int ch, input logic [31:0] d, input int stall, input bit ack_g);
        int exp_a;
        logic last;
        exp_a = base_of(ch, exp_buf[ch]) + exp_idx[ch] * 4;
        last  = (exp_idx[ch] == BUFW - 1);
        rx_evt[ch] = 1'b1;
        rx_data[ch*32 +: 32] = d;
        @(negedge clk);
        rx_evt[ch] = 1'b0;
        rx_data[ch*32 +: 32] = ~d;
        check("R2 req", wr_req[ch], 1);
        check("R3 addr", wr_addr[ch*AW +: AW], exp_a);
        check("R2 data", wr_data[ch*32 +: 32], d);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check("R2 hold req", wr_req[ch], 1);
            check("R2 hold addr", wr_addr[ch*AW +: AW], exp_a);
        end
        wr_gnt[ch] = 1'b1;
        if (ack_g) irq_ack[ch] = 1'b1;
        @(negedge clk);
        wr_gnt[ch] = 1'b0;
        irq_ack[ch] = 1'b0;
        check("R2 drop", wr_req[ch], 0);
        if (last) begin
            check("R6 pend", done_pend[ch], 1);
            check("R6 buf", done_buf[ch], exp_buf[ch]);
            check("R6 irq", irq, 1);
            exp_buf[ch] = 1 - exp_buf[ch];
            exp_idx[ch] = 0;
        end else begin
            exp_idx[ch]++;
        end
    endtask

    task automatic ack(input int ch);
        irq_ack[ch] = 1'b1;
        @(negedge clk);
        irq_ack[ch] = 1'b0;
        check("R7 pend clr", done_pend[ch], 0);
        check("R7 miss clr", missed[ch], 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            exp_idx[c] = 0;
            exp_buf[c] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 req", wr_req, 0);
        check("R1 irq", irq, 0);
        check("R1 pend", done_pend, 0);
        check("R1 miss", missed, 0);

        // R4 R5 R6 R10: ch0 buffers ping, pong without ack in between
        for (int w = 0; w < 2 * BUFW; w++)
            issue(0, 32'hA000_0000 + w * 32'h0101_0101, w % 3, 0);
        // R10 pending kept, done_buf shows latest (pong)
        check("R10 pend", done_pend[0], 1);
        check("R10 buf", done_buf[0], 1);
        // R9 other channel untouched
        check("R9 ch1 pend", done_pend[1], 0);
        check("R9 ch1 req", wr_req[1], 0);
        ack(0);
        check("R7 irq low", irq, 0);

        // R4: further ping/pong with acks, R7 simultaneous set wins
        for (int b = 0; b < 3; b++) begin
            for (int w = 0; w < BUFW; w++)
                issue(0, 32'h5A5A_0000 ^ (b * 256 + w), (w + b) % 2, (w == BUFW - 1) && (b == 1));
            check("R7 set wins", done_pend[0], 1);
            ack(0);
        end

        // R9 ch1 starts at its own ping base
        issue(1, 32'h1111_0001, 0, 0);
        check("R9 ch0 quiet", done_pend[0], 0);

        // R8 event while outstanding
        rx_evt[1] = 1'b1;
        rx_data[63:32] = 32'hDEAD_0001;
        @(negedge clk);
        check("R8 accepted req", wr_req[1], 1);
        check("R8 addr", wr_addr[AW +: AW], base_of(1, 0) + exp_idx[1] * 4);
        @(negedge clk);
        rx_evt[1] = 1'b0;
        check("R8 missed", missed[1], 1);
        check("R8 addr kept", wr_addr[AW +: AW], base_of(1, 0) + exp_idx[1] * 4);
        check("R8 data kept", wr_data[63:32], 32'hDEAD_0001);
        check("R9 ch0 miss", missed[0], 0);
        // event in the grant cycle is also dropped
        rx_evt[1] = 1'b1;
        wr_gnt[1] = 1'b1;
        @(negedge clk);
        rx_evt[1] = 1'b0;
        wr_gnt[1] = 1'b0;
        check("R8 gnt-cycle no req", wr_req[1], 0);
        exp_idx[1]++;
        ack(1);
        // next event continues at the following address, no skip
        for (int w = 0; w < 2 * BUFW; w++)
            issue(1, 32'hC0DE_0000 + w, w % 2, 0);
        check("R4 ch1 pend", done_pend[1], 1);
        ack(1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule